// File: doc/BRIEF.md
# Variable-length instruction form decoder

This block takes one 16-bit instruction word of a small 32-bit load/store processor and breaks it into control fields for the rest of the pipeline. It sorts the word into one of three formats by its top two bits, pulls out the register indices, the 8-bit short value, the branch condition and the raw 10-bit branch offset, and reports whether a 32-bit extension word follows. From that it gives the total instruction length in bytes. It marks illegal encodings and gives a register write-enable that is never raised for them.

Words enter on a valid/ready stream and leave on a valid/ready stream through one register stage. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or the sink takes the word it holds in that same cycle. While `out_valid` is high and `out_ready` is low, the held result stays unchanged and no new word is taken. Fetching the extension word, executing the operation and the register file all belong to other blocks.

Top module: `insn_form_decoder`

## Requirements
- R1: Format code `out_fmt` is 1 when word bit 15 is 0, 2 when bits 15:14 are 2'b10, and 3 when bits 15:14 are 2'b11.
- R2: Format 1: `out_op` = word[15:8], `out_ra` = word[7:4], `out_rb` = word[3:0].
- R3: Format 2: `out_op` = zero-extended word[13:12] (0 increment, 1 decrement, 2 read special register, 3 write special register), `out_ra` = word[11:8], `out_rb` = 0. For every format `out_imm8` = word[7:0].
- R4: Branch format: `out_cond` = word[13:10], `out_offs` = word[9:0], `out_op`, `out_ra` and `out_rb` are 0.
- R5: `out_len` is 6 for the format-1 codes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38, 0x39 and 2 for every other legal word.
- R6: `out_illegal` is 1 for format-1 codes 0x0F to 0x18 and 0x3A to 0x7F, and for branch conditions 10 to 15; every format-2 word is legal.
- R7: `out_we` (the operation's result goes to register `out_ra`) is 1 for format-2 operations 0 to 2 and for format-1 codes 0x01, 0x02, 0x05, 0x08, 0x0A, 0x0C, 0x1B, 0x1C, 0x1D, 0x20, 0x21, 0x22, 0x26 to 0x2F, 0x31 to 0x34, 0x36, 0x38; it is 0 otherwise and always 0 on an illegal word.
- R8: A word accepted at one clock edge shows on the outputs with `out_valid` high after exactly that edge; with no word accepted and `out_ready` high, `out_valid` falls after the next edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value.
- R10: Synchronous active-high `rst` clears `out_valid`, `out_illegal` and `out_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded fields present |
| out_ready | input | 1 | Sink takes the decoded fields |
| out_fmt | output | 2 | Format code 1, 2 or 3 |
| out_op | output | 8 | Operation code |
| out_ra | output | 4 | First register index |
| out_rb | output | 4 | Second register index |
| out_imm8 | output | 8 | Short unsigned value or special-register index |
| out_cond | output | 4 | Branch condition |
| out_offs | output | 10 | Raw branch offset |
| out_len | output | 3 | Instruction length in bytes, 2 or 6 |
| out_illegal | output | 1 | Encoding is illegal |
| out_we | output | 1 | Result written to register out_ra |

## Verification
The hard part is the boundary between legal and illegal codes, which sits at scattered points in format 1 and in the branch conditions. A full sweep of all 65536 words at one word per cycle reaches every such boundary, and the bench computes each expected field from the bit positions and code lists in the requirements. A stall is harder to reach, since it needs the sink to refuse while a fresh word waits at the input. A separate sequence drops `out_ready` just as a second word arrives. It then checks that the first result is held, that `in_ready` stays low, and that the second word shows up one edge after the stall is released.

// File: rtl/insn_form_pkg.sv
package insn_form_pkg;
  parameter int WORD_W   = 16;
  parameter int OP_W     = 8;
  parameter int RIDX_W   = 4;
  parameter int IMM_W    = 8;
  parameter int COND_W   = 4;
  parameter int OFFS_W   = 10;
  parameter int LEN_W    = 3;
  parameter int SUB2_W   = 2;
  parameter int LAST_OP  = 8'h39;
  parameter int HOLE_LO  = 8'h0F;
  parameter int HOLE_HI  = 8'h18;
  parameter int NUM_COND = 10;
  parameter int LEN_SHORT = 2;
  parameter int LEN_LONG  = 6;

  typedef enum logic [1:0] {
    FORM_NONE   = 2'd0,
    FORM_REG    = 2'd1,
    FORM_SHORT  = 2'd2,
    FORM_BRANCH = 2'd3
  } form_e;

  typedef struct packed {
    form_e               form;
    logic [OP_W-1:0]     op;
    logic [RIDX_W-1:0]   ra;
    logic [RIDX_W-1:0]   rb;
    logic [IMM_W-1:0]    imm;
    logic [COND_W-1:0]   cond;
    logic [OFFS_W-1:0]   offs;
  } fields_t;

  typedef struct packed {
    fields_t             f;
    logic [LEN_W-1:0]    len;
    logic                illegal;
    logic                we;
  } decoded_t;
endpackage

// File: rtl/insn_form_split.sv
module insn_form_split
  import insn_form_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fields_t           fields
);
  localparam int TOP = WORD_W - 1;

  always_comb begin
    fields      = '0;
    fields.imm  = word[IMM_W-1:0];
    fields.cond = word[OFFS_W+COND_W-1:OFFS_W];
    fields.offs = word[OFFS_W-1:0];
    if (!word[TOP]) begin
      fields.form = FORM_REG;
      fields.op   = word[TOP:TOP-OP_W+1];
      fields.ra   = word[2*RIDX_W-1:RIDX_W];
      fields.rb   = word[RIDX_W-1:0];
    end else if (!word[TOP-1]) begin
      fields.form = FORM_SHORT;
      fields.op   = {{(OP_W-SUB2_W){1'b0}}, word[TOP-2:TOP-1-SUB2_W]};
      fields.ra   = word[IMM_W+RIDX_W-1:IMM_W];
    end else begin
      fields.form = FORM_BRANCH;
    end
  end
endmodule

// File: rtl/insn_form_class.sv
module insn_form_class
  import insn_form_pkg::*;
(
  input  fields_t          fields,
  output logic [LEN_W-1:0] len,
  output logic             illegal,
  output logic             we
);
  logic long_f1, we_f1, bad_f1;

  always_comb begin
    bad_f1 = (fields.op >= OP_W'(HOLE_LO) && fields.op <= OP_W'(HOLE_HI))
          || (fields.op > OP_W'(LAST_OP));
    unique case (fields.op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B, 8'h1D,
      8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39:
        long_f1 = 1'b1;
      default: long_f1 = 1'b0;
    endcase
    unique case (fields.op)
      8'h01, 8'h02, 8'h05, 8'h08, 8'h0A, 8'h0C, 8'h1B, 8'h1C, 8'h1D,
      8'h20, 8'h21, 8'h22, 8'h26, 8'h27, 8'h28, 8'h29, 8'h2A, 8'h2B,
      8'h2C, 8'h2D, 8'h2E, 8'h2F, 8'h31, 8'h32, 8'h33, 8'h34, 8'h36,
      8'h38:
        we_f1 = 1'b1;
      default: we_f1 = 1'b0;
    endcase
  end

  always_comb begin
    len     = LEN_W'(LEN_SHORT);
    illegal = 1'b0;
    we      = 1'b0;
    unique case (fields.form)
      FORM_REG: begin
        illegal = bad_f1;
        we      = we_f1 && !bad_f1;
        if (long_f1) len = LEN_W'(LEN_LONG);
      end
      FORM_SHORT: begin
        we = (fields.op[SUB2_W-1:0] != 2'd3);
      end
      FORM_BRANCH: begin
        illegal = (fields.cond >= COND_W'(NUM_COND));
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/insn_form_stage.sv
module insn_form_stage
  import insn_form_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  output logic     in_ready,
  input  decoded_t in_data,
  output logic     out_valid,
  input  logic     out_ready,
  output decoded_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_data.len <= LEN_W'(LEN_SHORT);
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/insn_form_decoder.sv
module insn_form_decoder
  import insn_form_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_fmt,
  output logic [7:0]  out_op,
  output logic [3:0]  out_ra,
  output logic [3:0]  out_rb,
  output logic [7:0]  out_imm8,
  output logic [3:0]  out_cond,
  output logic [9:0]  out_offs,
  output logic [2:0]  out_len,
  output logic        out_illegal,
  output logic        out_we
);
  fields_t  fld;
  decoded_t dec, held;

  insn_form_split u_split (.word(in_word), .fields(fld));

  insn_form_class u_class (
    .fields(fld), .len(dec.len), .illegal(dec.illegal), .we(dec.we)
  );
  assign dec.f = fld;

  insn_form_stage u_stage (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(dec),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(held)
  );

  assign out_fmt     = held.f.form;
  assign out_op      = held.f.op;
  assign out_ra      = held.f.ra;
  assign out_rb      = held.f.rb;
  assign out_imm8    = held.f.imm;
  assign out_cond    = held.f.cond;
  assign out_offs    = held.f.offs;
  assign out_len     = held.len;
  assign out_illegal = held.illegal;
  assign out_we      = held.we;
endmodule

// File: rtl/insn_form_decoder_chk.sv
module insn_form_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_word,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_fmt,
  input logic [7:0]  out_op,
  input logic [2:0]  out_len,
  input logic        out_illegal,
  input logic        out_we
);
  p_fmt_one_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_word[15]) |=> (out_fmt == 2'd1));

  p_branch_fmt_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_word[15] && in_word[14]) |=> (out_fmt == 2'd3));

  p_len_set_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len == 3'd2 || out_len == 3'd6));

  p_short_legal_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fmt == 2'd2) |-> !out_illegal);

  p_no_we_illegal_r7: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_we);

  p_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_fmt)
                                   && $stable(out_len) && $stable(out_illegal)));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal && !out_we));
endmodule

bind insn_form_decoder insn_form_decoder_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_fmt(out_fmt), .out_op(out_op), .out_len(out_len),
  .out_illegal(out_illegal), .out_we(out_we)
);

// File: tb/insn_form_decoder_test.sv
module insn_form_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_fmt;
  logic [7:0]  out_op;
  logic [3:0]  out_ra, out_rb, out_cond;
  logic [7:0]  out_imm8;
  logic [9:0]  out_offs;
  logic [2:0]  out_len;
  logic        out_illegal, out_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  insn_form_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_fmt(out_fmt), .out_op(out_op), .out_ra(out_ra), .out_rb(out_rb),
    .out_imm8(out_imm8), .out_cond(out_cond), .out_offs(out_offs),
    .out_len(out_len), .out_illegal(out_illegal), .out_we(out_we)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_long(logic [7:0] c);
    case (c)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B, 8'h1D,
      8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit writes_ra(logic [7:0] c);
    if (c >= 8'h26 && c <= 8'h2F) return 1;
    if (c >= 8'h31 && c <= 8'h34) return 1;
    case (c)
      8'h01, 8'h02, 8'h05, 8'h08, 8'h0A, 8'h0C, 8'h1B, 8'h1C, 8'h1D,
      8'h20, 8'h21, 8'h22, 8'h36, 8'h38: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check_word(logic [15:0] w);
    int fmt;
    bit bad, we;
    int len, op, ra, rb;
    fmt = w[15] ? (w[14] ? 3 : 2) : 1;
    bad = 0; we = 0; len = 2; op = 0; ra = 0; rb = 0;
    if (fmt == 1) begin
      op = w[15:8]; ra = w[7:4]; rb = w[3:0];
      bad = (op >= 8'h0F && op <= 8'h18) || op > 8'h39;
      we  = !bad && writes_ra(w[15:8]);
      len = is_long(w[15:8]) ? 6 : 2;
    end else if (fmt == 2) begin
      op = w[13:12]; ra = w[11:8];
      we = (w[13:12] != 2'd3);
    end else begin
      bad = (w[13:10] >= 4'd10);
    end
    chk("R8 out_valid", 32'(out_valid), 1);
    chk("R1 fmt", 32'(out_fmt), 32'(fmt));
    chk("R6 illegal", 32'(out_illegal), 32'(bad));
    chk("R7 we", 32'(out_we), 32'(we));
    if (!bad) begin
      chk("R2 R3 R4 op", 32'(out_op), 32'(op));
      chk("R2 R3 R4 ra", 32'(out_ra), 32'(ra));
      chk("R2 R3 R4 rb", 32'(out_rb), 32'(rb));
      chk("R3 imm8", 32'(out_imm8), 32'(w[7:0]));
      chk("R5 len", 32'(out_len), 32'(len));
      if (fmt == 3) begin
        chk("R4 cond", 32'(out_cond), 32'(w[13:10]));
        chk("R4 offs", 32'(out_offs), 32'(w[9:0]));
      end
    end
  endtask

  initial begin
    for (int n = 0; n < 200000; n++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid", 32'(out_valid), 0);
    chk("R10 out_illegal", 32'(out_illegal), 0);
    chk("R10 out_we", 32'(out_we), 0);
    rst = 1'b0;

    // full sweep, one word per cycle
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (i > 0) check_word(16'(i - 1));
      in_word  = 16'(i);
      in_valid = 1'b1;
    end
    @(negedge clk);
    check_word(16'hFFFF);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 out_valid drops", 32'(out_valid), 0);

    // R9: stall with a second word waiting
    in_word = 16'h0123; in_valid = 1'b1;
    @(negedge clk);
    check_word(16'h0123);
    out_ready = 1'b0;
    in_word = 16'h8A55;
    #1;
    chk("R9 in_ready low", 32'(in_ready), 0);
    @(negedge clk);
    chk("R9 held op", 32'(out_op), 32'h01);
    chk("R9 held len", 32'(out_len), 6);
    chk("R9 held valid", 32'(out_valid), 1);
    chk("R9 held ra", 32'(out_ra), 2);
    out_ready = 1'b1;
    @(negedge clk);
    check_word(16'h8A55);
    in_valid = 1'b0;

    // R10: reset mid-stream clears the flags
    in_word = 16'h7F00; in_valid = 1'b1;
    @(negedge clk);
    chk("R6 illegal before reset", 32'(out_illegal), 1);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R10 valid after reset", 32'(out_valid), 0);
    chk("R10 illegal after reset", 32'(out_illegal), 0);
    rst = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule